// File: doc/BRIEF.md
# T1 Receive Timing Pulse Generator

This block produces the receive-side timing strobes of a T1 line. It runs on the 1.544 MHz receive bit clock. It counts the framing bit, the 24 eight-bit channel slots and the frame number within the multiframe. It starts counting on a synchronous alignment pulse, and a later alignment pulse re-phases it at any time. From the counts it builds five registered outputs:

- a channel strobe on the last bit of every slot;
- a per-channel gate taken from a 24-bit mask;
- a frame marker;
- a selectable frame or multiframe sync, which can be widened on signaling frames;
- a data-link clock whose rate depends on the framing mode.

A frame is 193 bit times long. The framing bit comes first, followed by channels 0 to 23. Each channel is sent most significant bit first, so the last bit of channel n falls at frame bit 8n+8. A superframe multiframe has 12 frames and an extended superframe has 24. In both, every sixth frame is a signaling frame. Control inputs are plain levels. The mask is read at the start of each slot.

Top module: `t1_rx_timing`

## Requirements
- R1: During reset, and after reset until the first alignment pulse is sampled, every output is low.
- R2: An alignment pulse sampled on a clock edge places the block at frame bit 0 of frame 1 from that edge on. frame_sync_o is high for that one cycle, and then again every 193 cycles.
- R3: chan_clk_o is high for exactly one cycle at frame bits 8n+8 (n = 0..23), which gives 24 pulses per frame. It is never high on the framing bit (bit 0).
- R4: chan_blk_o equals blk_mask_i[n] for all eight bits of channel n (bit positions 8n+1 to 8n+8), and it is low on the framing bit. The mask value used for a slot is the one present at the edge that enters the slot's first bit. A mask change in the middle of a slot takes effect at the next slot.
- R5: With multi_sel_i = 0 and wide_sig_i = 0, rx_sync_o is a one-cycle pulse on the framing bit of every frame.
- R6: With multi_sel_i = 1, rx_sync_o pulses for one cycle on the framing bit of frame 1 only. The multiframe is 12 frames when esf_i = 0 and 24 frames when esf_i = 1.
- R7: With multi_sel_i = 0 and wide_sig_i = 1, rx_sync_o stays high on frame bits 0 and 1 of signaling frames (frame numbers divisible by 6), and on bit 0 only in other frames. wide_sig_i has no effect when multi_sel_i = 1.
- R8: With esf_i = 1 and alt_link_i = 0, link_clk_o is high during odd-numbered frames and low during even ones, a period of 2 frames (4 kHz). It changes only on a framing bit.
- R9: With esf_i = 1 and alt_link_i = 1, link_clk_o is high in frames f where (f-1) mod 4 is 0 or 1, a period of 4 frames (2 kHz).
- R10: With esf_i = 0, link_clk_o stays low.
- R11: An alignment pulse in the middle of a frame restarts the count at bit 0 of frame 1, and frame_sync_o is high in the cycle after the edge that samples the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| align_i | input | 1 | Frame alignment pulse; restarts the count at bit 0 of frame 1 |
| esf_i | input | 1 | 1 selects the 24-frame multiframe, 0 the 12-frame one |
| multi_sel_i | input | 1 | Sync marks frames (0) or multiframes (1) |
| wide_sig_i | input | 1 | Widen the frame sync to two cycles on signaling frames |
| alt_link_i | input | 1 | Selects the half-rate (2 kHz) link clock |
| blk_mask_i | input | 24 | Per-channel gate level; bit n belongs to channel n |
| chan_clk_o | output | 1 | Last-bit strobe of each channel |
| chan_blk_o | output | 1 | Per-channel gate output |
| rx_sync_o | output | 1 | Frame or multiframe sync pulse |
| frame_sync_o | output | 1 | Frame marker on every framing bit |
| link_clk_o | output | 1 | Data-link clock |

## Verification
The hardest cases to reach are those tied to the long multiframe. The 24-frame wrap, the widened pulses on frames 18 and 24, and the phase of the half-rate link clock only show after about 4,600 bit clocks from a single alignment. The stimulus therefore holds each mode steady for more than a full multiframe after a fresh alignment. A bit-accurate position model in the bench predicts every output on every cycle. A mid-slot mask change and an alignment pulse landing in the middle of a frame are placed at chosen bit positions, read from that model, to hit the slot-boundary and re-phase corner cases.

// File: rtl/t1rx_pkg.sv
package t1rx_pkg;
   localparam int unsigned DEF_CHANNELS   = 24;
   localparam int unsigned DEF_SLOT_BITS  = 8;
   localparam int unsigned DEF_SF_FRAMES  = 12;
   localparam int unsigned DEF_ESF_FRAMES = 24;
   localparam int unsigned DEF_SIG_EVERY  = 6;
   localparam int unsigned DEF_LINK_NORM  = 2;
   localparam int unsigned DEF_LINK_ALT   = 4;

   typedef enum logic {
      MARK_FRAME = 1'b0,
      MARK_MULTI = 1'b1
   } sync_sel_e;
endpackage

// File: rtl/t1rx_pos_counter.sv
module t1rx_pos_counter #(
   parameter int unsigned CHANNELS   = 24,
   parameter int unsigned SLOT_BITS  = 8,
   parameter int unsigned SF_FRAMES  = 12,
   parameter int unsigned ESF_FRAMES = 24,
   localparam int unsigned CW = $clog2(CHANNELS),
   localparam int unsigned SW = $clog2(SLOT_BITS),
   localparam int unsigned FW = $clog2(ESF_FRAMES + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          align_i,
   input  logic          esf_i,
   output logic          run_o,
   output logic          n_run_o,
   output logic          n_fbit_o,
   output logic [SW-1:0] n_sub_o,
   output logic [CW-1:0] n_ch_o,
   output logic [FW-1:0] n_frame_o
);
   logic          run_q, fbit_q;
   logic [SW-1:0] sub_q;
   logic [CW-1:0] ch_q;
   logic [FW-1:0] frame_q;
   logic [FW-1:0] last_frame;
   logic          slot_end, frame_end;

   assign last_frame = esf_i ? FW'(ESF_FRAMES) : FW'(SF_FRAMES);
   assign slot_end   = (sub_q == SW'(SLOT_BITS - 1));
   assign frame_end  = slot_end && (ch_q == CW'(CHANNELS - 1));

   always_comb begin
      n_run_o   = run_q;
      n_fbit_o  = fbit_q;
      n_sub_o   = sub_q;
      n_ch_o    = ch_q;
      n_frame_o = frame_q;
      if (align_i) begin
         n_run_o   = 1'b1;
         n_fbit_o  = 1'b1;
         n_sub_o   = '0;
         n_ch_o    = '0;
         n_frame_o = FW'(1);
      end else if (run_q) begin
         if (fbit_q) begin
            n_fbit_o = 1'b0;
            n_sub_o  = '0;
            n_ch_o   = '0;
         end else if (frame_end) begin
            n_fbit_o  = 1'b1;
            n_sub_o   = '0;
            n_ch_o    = '0;
            n_frame_o = (frame_q >= last_frame) ? FW'(1) : frame_q + FW'(1);
         end else if (slot_end) begin
            n_sub_o = '0;
            n_ch_o  = ch_q + CW'(1);
         end else begin
            n_sub_o = sub_q + SW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q   <= 1'b0;
         fbit_q  <= 1'b1;
         sub_q   <= '0;
         ch_q    <= '0;
         frame_q <= FW'(1);
      end else begin
         run_q   <= n_run_o;
         fbit_q  <= n_fbit_o;
         sub_q   <= n_sub_o;
         ch_q    <= n_ch_o;
         frame_q <= n_frame_o;
      end
   end

   assign run_o = run_q;

   assert_slot_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (run_q && !align_i && !fbit_q && frame_end) |=> fbit_q);

   assert_frame_wrap_R6: assert property (@(posedge clk) disable iff (rst)
      (run_q && !align_i && !fbit_q && frame_end && frame_q >= last_frame)
      |=> (frame_q == FW'(1)));

   assert_align_restart_R11: assert property (@(posedge clk) disable iff (rst)
      align_i |=> (run_q && fbit_q && frame_q == FW'(1)));
endmodule

// File: rtl/t1rx_slot_decode.sv
module t1rx_slot_decode #(
   parameter int unsigned CHANNELS  = 24,
   parameter int unsigned SLOT_BITS = 8,
   localparam int unsigned CW = $clog2(CHANNELS),
   localparam int unsigned SW = $clog2(SLOT_BITS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                n_run_i,
   input  logic                n_fbit_i,
   input  logic [SW-1:0]       n_sub_i,
   input  logic [CW-1:0]       n_ch_i,
   input  logic [CHANNELS-1:0] mask_i,
   output logic                chan_clk_o,
   output logic                chan_blk_o
);
   logic in_slot, slot_first, slot_last;

   assign in_slot    = n_run_i && !n_fbit_i;
   assign slot_first = in_slot && (n_sub_i == '0);
   assign slot_last  = in_slot && (n_sub_i == SW'(SLOT_BITS - 1));

   always_ff @(posedge clk) begin
      if (rst || !n_run_i) begin
         chan_clk_o <= 1'b0;
         chan_blk_o <= 1'b0;
      end else begin
         chan_clk_o <= slot_last;
         if (!in_slot)
            chan_blk_o <= 1'b0;
         else if (slot_first)
            chan_blk_o <= mask_i[n_ch_i];
      end
   end

   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
      chan_clk_o |=> !chan_clk_o);
endmodule

// File: rtl/t1rx_frame_marks.sv
module t1rx_frame_marks
   import t1rx_pkg::*;
#(
   parameter int unsigned CHANNELS   = 24,
   parameter int unsigned SLOT_BITS  = 8,
   parameter int unsigned ESF_FRAMES = 24,
   parameter int unsigned SIG_EVERY  = 6,
   parameter int unsigned LINK_NORM  = 2,
   parameter int unsigned LINK_ALT   = 4,
   localparam int unsigned CW = $clog2(CHANNELS),
   localparam int unsigned SW = $clog2(SLOT_BITS),
   localparam int unsigned FW = $clog2(ESF_FRAMES + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          n_run_i,
   input  logic          n_fbit_i,
   input  logic [SW-1:0] n_sub_i,
   input  logic [CW-1:0] n_ch_i,
   input  logic [FW-1:0] n_frame_i,
   input  logic          mark_sel_i,
   input  logic          wide_i,
   input  logic          esf_i,
   input  logic          alt_link_i,
   output logic          frm_sync_o,
   output logic          rx_sync_o,
   output logic          link_clk_o
);
   logic [ESF_FRAMES:0] sig_map;
   logic                first_bit, second_bit, ext_q, link_n;
   sync_sel_e           mode;
   int                  fidx, per;

   for (genvar i = 0; i <= ESF_FRAMES; i++) begin : g_sig
      assign sig_map[i] = (i != 0) && ((i % SIG_EVERY) == 0);
   end

   assign mode       = sync_sel_e'(mark_sel_i);
   assign first_bit  = n_run_i && n_fbit_i;
   assign second_bit = n_run_i && !n_fbit_i && (n_sub_i == '0) && (n_ch_i == '0);

   always_comb begin
      per    = alt_link_i ? int'(LINK_ALT) : int'(LINK_NORM);
      fidx   = (n_frame_i == '0) ? 0 : int'(n_frame_i) - 1;
      link_n = esf_i && ((fidx % per) < (per / 2));
   end

   always_ff @(posedge clk) begin
      if (rst || !n_run_i) begin
         frm_sync_o <= 1'b0;
         rx_sync_o  <= 1'b0;
         link_clk_o <= 1'b0;
         ext_q      <= 1'b0;
      end else begin
         frm_sync_o <= first_bit;
         if (first_bit) begin
            rx_sync_o  <= (mode == MARK_MULTI) ? (n_frame_i == FW'(1)) : 1'b1;
            ext_q      <= (mode == MARK_FRAME) && wide_i && sig_map[n_frame_i];
            link_clk_o <= link_n;
         end else begin
            rx_sync_o <= second_bit && ext_q;
            ext_q     <= 1'b0;
         end
      end
   end

   assert_wide_follows_R7: assert property (@(posedge clk) disable iff (rst)
      (rx_sync_o && !frm_sync_o) |-> $past(rx_sync_o));

   assert_link_on_frame_R8: assert property (@(posedge clk) disable iff (rst)
      !$stable(link_clk_o) |-> frm_sync_o);

   assert_frame_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      frm_sync_o |=> (!frm_sync_o || $past(n_run_i && n_fbit_i)));
endmodule

// File: rtl/t1_rx_timing.sv
module t1_rx_timing
   import t1rx_pkg::*;
#(
   parameter int unsigned CHANNELS   = DEF_CHANNELS,
   parameter int unsigned SLOT_BITS  = DEF_SLOT_BITS,
   parameter int unsigned SF_FRAMES  = DEF_SF_FRAMES,
   parameter int unsigned ESF_FRAMES = DEF_ESF_FRAMES,
   parameter int unsigned SIG_EVERY  = DEF_SIG_EVERY,
   parameter int unsigned LINK_NORM  = DEF_LINK_NORM,
   parameter int unsigned LINK_ALT   = DEF_LINK_ALT,
   localparam int unsigned CW = $clog2(CHANNELS),
   localparam int unsigned SW = $clog2(SLOT_BITS),
   localparam int unsigned FW = $clog2(ESF_FRAMES + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                align_i,
   input  logic                esf_i,
   input  logic                multi_sel_i,
   input  logic                wide_sig_i,
   input  logic                alt_link_i,
   input  logic [CHANNELS-1:0] blk_mask_i,
   output logic                chan_clk_o,
   output logic                chan_blk_o,
   output logic                rx_sync_o,
   output logic                frame_sync_o,
   output logic                link_clk_o
);
   initial begin
      assert (CHANNELS >= 2) else $error("CHANNELS must be at least 2");
      assert (SLOT_BITS >= 2) else $error("SLOT_BITS must be at least 2");
      assert (SF_FRAMES >= 1 && ESF_FRAMES >= SF_FRAMES)
         else $error("multiframe lengths inconsistent");
      assert (SIG_EVERY >= 1) else $error("SIG_EVERY must be nonzero");
      assert (LINK_NORM >= 2 && LINK_ALT >= 2 && LINK_NORM % 2 == 0 && LINK_ALT % 2 == 0)
         else $error("link periods must be even and at least 2");
   end

   logic          run, n_run, n_fbit;
   logic [SW-1:0] n_sub;
   logic [CW-1:0] n_ch;
   logic [FW-1:0] n_frame;

   t1rx_pos_counter #(
      .CHANNELS(CHANNELS), .SLOT_BITS(SLOT_BITS),
      .SF_FRAMES(SF_FRAMES), .ESF_FRAMES(ESF_FRAMES)
   ) u_cnt (
      .clk(clk), .rst(rst), .align_i(align_i), .esf_i(esf_i),
      .run_o(run), .n_run_o(n_run), .n_fbit_o(n_fbit),
      .n_sub_o(n_sub), .n_ch_o(n_ch), .n_frame_o(n_frame)
   );

   t1rx_slot_decode #(
      .CHANNELS(CHANNELS), .SLOT_BITS(SLOT_BITS)
   ) u_slot (
      .clk(clk), .rst(rst), .n_run_i(n_run), .n_fbit_i(n_fbit),
      .n_sub_i(n_sub), .n_ch_i(n_ch), .mask_i(blk_mask_i),
      .chan_clk_o(chan_clk_o), .chan_blk_o(chan_blk_o)
   );

   t1rx_frame_marks #(
      .CHANNELS(CHANNELS), .SLOT_BITS(SLOT_BITS), .ESF_FRAMES(ESF_FRAMES),
      .SIG_EVERY(SIG_EVERY), .LINK_NORM(LINK_NORM), .LINK_ALT(LINK_ALT)
   ) u_marks (
      .clk(clk), .rst(rst), .n_run_i(n_run), .n_fbit_i(n_fbit),
      .n_sub_i(n_sub), .n_ch_i(n_ch), .n_frame_i(n_frame),
      .mark_sel_i(multi_sel_i), .wide_i(wide_sig_i), .esf_i(esf_i),
      .alt_link_i(alt_link_i),
      .frm_sync_o(frame_sync_o), .rx_sync_o(rx_sync_o), .link_clk_o(link_clk_o)
   );

   assert_quiet_until_align_R1: assert property (@(posedge clk) disable iff (rst)
      (chan_clk_o || chan_blk_o || rx_sync_o || frame_sync_o || link_clk_o) |-> run);

   assert_no_strobe_on_fbit_R3: assert property (@(posedge clk) disable iff (rst)
      chan_clk_o |-> !frame_sync_o);

   assert_gate_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable(chan_blk_o) |-> ($past(chan_clk_o) || $past(frame_sync_o) || frame_sync_o));
endmodule

// File: tb/tb_t1_rx_timing.sv
`timescale 1ns/1ps
module tb_t1_rx_timing;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        align_i = 1'b0, esf_i = 1'b0, multi_sel_i = 1'b0;
   logic        wide_sig_i = 1'b0, alt_link_i = 1'b0;
   logic [23:0] blk_mask_i = '0;
   logic        chan_clk_o, chan_blk_o, rx_sync_o, frame_sync_o, link_clk_o;

   int checks = 0, errors = 0;
   bit done = 0;

   int  m_b = 0, m_f = 1;
   bit  m_run = 0, m_blk = 0, m_link = 0;

   t1_rx_timing dut (
      .clk(clk), .rst(rst), .align_i(align_i), .esf_i(esf_i),
      .multi_sel_i(multi_sel_i), .wide_sig_i(wide_sig_i), .alt_link_i(alt_link_i),
      .blk_mask_i(blk_mask_i), .chan_clk_o(chan_clk_o), .chan_blk_o(chan_blk_o),
      .rx_sync_o(rx_sync_o), .frame_sync_o(frame_sync_o), .link_clk_o(link_clk_o)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input logic act, input logic exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0b expected=%0b (bit %0d frame %0d)",
                  tag, what, act, exp, m_b, m_f);
      end
   endtask

   // model update after one edge, from the requirements
   task automatic model_step(input bit a);
      int n;
      n = esf_i ? 24 : 12;
      if (rst) begin
         m_run = 0; m_b = 0; m_f = 1; m_blk = 0; m_link = 0;
      end else if (a) begin
         m_run = 1; m_b = 0; m_f = 1;
      end else if (m_run) begin
         if (m_b == 192) begin
            m_b = 0;
            m_f = (m_f >= n) ? 1 : m_f + 1;
         end else m_b++;
      end
      if (m_run && !rst) begin
         if (m_b == 0) begin
            m_blk = 0;
            if (!esf_i) m_link = 0;
            else if (alt_link_i) m_link = (((m_f - 1) % 4) < 2);
            else m_link = (m_f % 2) == 1;
         end else if (((m_b - 1) % 8) == 0) m_blk = blk_mask_i[(m_b - 1) / 8];
      end
   endtask

   task automatic compare_all();
      bit    e_sync;
      string st, lt;
      if (!m_run) begin
         chk(chan_clk_o, 0, "R1", "chan_clk idle");
         chk(chan_blk_o, 0, "R1", "chan_blk idle");
         chk(rx_sync_o, 0, "R1", "rx_sync idle");
         chk(frame_sync_o, 0, "R1", "frame_sync idle");
         chk(link_clk_o, 0, "R1", "link_clk idle");
         return;
      end
      chk(frame_sync_o, m_b == 0, "R2", "frame_sync");
      chk(chan_clk_o, (m_b != 0) && (m_b % 8 == 0), "R3", "chan_clk");
      chk(chan_blk_o, m_blk, "R4", "chan_blk");
      if (multi_sel_i) begin
         e_sync = (m_b == 0) && (m_f == 1); st = "R6";
      end else if (wide_sig_i) begin
         e_sync = (m_b == 0) || ((m_b == 1) && (m_f % 6 == 0)); st = "R7";
      end else begin
         e_sync = (m_b == 0); st = "R5";
      end
      chk(rx_sync_o, e_sync, st, "rx_sync");
      lt = !esf_i ? "R10" : (alt_link_i ? "R9" : "R8");
      chk(link_clk_o, m_link, lt, "link_clk");
   endtask

   // called at negedge: drive, clock, update model, compare at next negedge
   task automatic tick(input bit a);
      align_i = a;
      @(posedge clk);
      model_step(a);
      @(negedge clk);
      align_i = 1'b0;
      compare_all();
   endtask

   task automatic run_frames(input int frames);
      tick(1);
      for (int i = 1; i < frames * 193; i++) tick(0);
   endtask

   task automatic t_reset();   // R1
      rst = 1'b1;
      for (int i = 0; i < 4; i++) tick(0);
      rst = 1'b0;
      for (int i = 0; i < 6; i++) tick(0);
   endtask

   task automatic t_frame_sf();   // R2 R3 R4 R5 R10
      esf_i = 0; multi_sel_i = 0; wide_sig_i = 0; alt_link_i = 0;
      blk_mask_i = 24'hA53C81;
      run_frames(3);
   endtask

   task automatic t_multi(input bit esf, input bit wide, input int frames);   // R6 R7
      esf_i = esf; multi_sel_i = 1; wide_sig_i = wide; alt_link_i = 0;
      blk_mask_i = 24'h5F0096;
      run_frames(frames);
   endtask

   task automatic t_wide_esf();   // R7 R8
      esf_i = 1; multi_sel_i = 0; wide_sig_i = 1; alt_link_i = 0;
      blk_mask_i = 24'hFFFFFF;
      run_frames(25);
   endtask

   task automatic t_link_alt();   // R9
      esf_i = 1; multi_sel_i = 0; wide_sig_i = 0; alt_link_i = 1;
      blk_mask_i = 24'h000001;
      run_frames(9);
   endtask

   task automatic t_realign();   // R11
      esf_i = 1; multi_sel_i = 0; wide_sig_i = 0; alt_link_i = 0;
      blk_mask_i = 24'h800000;
      run_frames(2);
      for (int i = 0; i < 77; i++) tick(0);
      tick(1);
      checks++;
      if (frame_sync_o !== 1'b1 || m_b != 0 || m_f != 1) begin
         errors++;
         $display("FAIL R11 realign frame_sync: actual=%0b expected=1", frame_sync_o);
      end
      for (int i = 0; i < 2 * 193; i++) tick(0);
   endtask

   task automatic t_mask_mid();   // R4
      esf_i = 0; multi_sel_i = 0; wide_sig_i = 0; alt_link_i = 0;
      blk_mask_i = 24'h000000;
      tick(1);
      while (m_b != 19) tick(0);
      blk_mask_i = 24'hFFFFFF;
      while (m_b != 24) tick(0);
      chk(chan_blk_o, 0, "R4", "mask change mid slot held");
      tick(0);
      chk(chan_blk_o, 1, "R4", "mask change taken at next slot");
      for (int i = 0; i < 193; i++) tick(0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_frame_sf();
      t_multi(0, 0, 13);
      t_multi(1, 0, 25);
      t_multi(0, 1, 13);
      t_wide_esf();
      t_link_alt();
      t_realign();
      t_mask_mid();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog R1: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule